// File: doc/BRIEF.md
# XOR Sprite Blitter with Erase Detection

This block draws a small monochrome sprite into a one-bit-per-pixel framebuffer of 64 columns by 32 rows. A caller gives a start strobe together with a sprite base address, an x and a y coordinate and a row count. The engine then fetches one sprite byte per row from a byte-wide main-memory read port. It walks the eight pixels of that row, one pixel per clock, and toggles each target pixel through a single-bit framebuffer port. The port reads within the cycle and writes at the next edge.

Each row byte is painted with its most significant bit leftmost. A pixel takes the old framebuffer bit XOR the sprite bit. Pixels that run past the right or bottom edge reappear on the opposite side. When the draw ends, the engine raises a one-cycle completion pulse. It also presents an erase flag that tells whether any lit pixel was switched off. That flag is meant for the host's flag register.

Top module: `sprite_xor_blitter`

## Requirements
- R1: While and after reset, `busy`, `done`, `collide`, `mem_rd` and `fb_wr` are all 0.
- R2: Sprite row r (0-based) is fetched by exactly one `mem_rd` cycle at address `spr_base + r` modulo 2^ADDR_W. Rows are fetched in increasing r, so a base of 0xFFF is followed by 0x000.
- R3: Within a row byte, bit 7 is painted at column offset 0 and bit 0 at column offset 7.
- R4: Every one of the 8 pixels of every row is written exactly once with `fb_wdata` = `fb_rdata` XOR sprite bit. A draw of n rows gives exactly 8·n `fb_wr` cycles.
- R5: `collide` is cleared when a draw is accepted. It is 1 after the draw when at least one pixel went from 1 to 0, and 0 otherwise. It holds its value until the next accepted start.
- R6: For row r and column offset k, the framebuffer address is row·64 + col. Here col = (pos_x + k) mod 64 and row = (pos_y + r) mod 32, each computed per pixel.
- R7: A row count of 0 completes with `done` on the first edge after the start and `collide` 0. It makes no memory reads and no framebuffer writes.
- R8: For a draw of n rows, `done` rises 10·n + 1 clock edges after the edge that accepts the start, counting that edge. `done` is high for exactly one cycle.
- R9: A `start` presented while `busy` is 1 is ignored. The draw in progress finishes with its original parameters and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Draw request, accepted when not busy |
| spr_base | input | ADDR_W (12) | Address of the first sprite byte |
| pos_x | input | COORD_W (8) | Column of the sprite's left edge, wraps mod 64 |
| pos_y | input | COORD_W (8) | Row of the sprite's top edge, wraps mod 32 |
| spr_rows | input | HEIGHT_W (4) | Number of sprite rows |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle completion pulse |
| collide | output | 1 | A lit pixel was erased during the last draw |
| mem_rd | output | 1 | Memory read request; data returns the next cycle |
| mem_addr | output | ADDR_W (12) | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| fb_addr | output | FB_AW (11) | Framebuffer pixel address |
| fb_rdata | input | 1 | Current framebuffer bit at `fb_addr` (same-cycle read) |
| fb_wr | output | 1 | Framebuffer write enable |
| fb_wdata | output | 1 | Framebuffer write data |

## Verification
The bench builds the block with its default parameters: 64×32 screen, 12-bit memory address, 8-bit coordinates and a 4-bit row count. Coordinates above 63 and 31 can therefore wrap before any pixel offset is added. The bottom-right corner wraps to the top-left, and a base address of 0xFFF rolls over to 0x000. The 4-bit count reaches 15-row sprites, which span almost half the screen height. It also reaches the 0-row case, together with the exact latency formula at both ends of the range.

// File: rtl/sprite_blit_pkg.sv
// Shared types and constants of the sprite blitter.
// Assumes a sprite row is always one byte wide.
package sprite_blit_pkg;

    // Sequencer states of one draw.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DRAW  = 3'd3,
        ST_DONE  = 3'd4
    } blit_state_e;

    // Pixels packed in one sprite byte.
    localparam int PIX_PER_ROW  = 8;
    // Cycles spent per row besides drawing: request and data capture.
    localparam int ROW_OVERHEAD = 2;

endpackage

// File: rtl/blit_addr_gen.sv
// Pixel address generator.
// Turns the sprite origin plus the current row and column offset into a
// framebuffer address. The column wraps modulo COLS and the row modulo ROWS,
// each on its own, so a sprite crossing an edge reappears on the far side.
// Assumes a row-major framebuffer: address = row * COLS + col.
module blit_addr_gen #(
    parameter int COLS     = 64,
    parameter int ROWS     = 32,
    parameter int COORD_W  = 8,
    parameter int HEIGHT_W = 4,
    parameter int BIT_W    = 3,
    parameter int FB_AW    = $clog2(COLS * ROWS)
) (
    input  logic [COORD_W-1:0]  org_x,
    input  logic [COORD_W-1:0]  org_y,
    input  logic [HEIGHT_W-1:0] row_idx,
    input  logic [BIT_W-1:0]    bit_idx,
    output logic [FB_AW-1:0]    pix_addr
);

    localparam int SUM_W = ((COORD_W > HEIGHT_W) ? COORD_W : HEIGHT_W) + 1;
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;

    // Wrapped column and row of the current pixel.
    always_comb begin
        col = COL_W'((SUM_W'(org_x) + SUM_W'(bit_idx)) % SUM_W'(COLS));
        row = ROW_W'((SUM_W'(org_y) + SUM_W'(row_idx)) % SUM_W'(ROWS));
    end

    // Row-major linear address.
    always_comb begin
        pix_addr = FB_AW'(row) * FB_AW'(COLS) + FB_AW'(col);
    end

endmodule

// File: rtl/blit_pixel_merge.sv
// Pixel merge and erase detector.
// Produces the new pixel value (old XOR sprite bit) and accumulates the
// erase flag over a draw: a lit pixel hit by a lit sprite bit sets it.
// Assumes clr and draw_en are never high in the same cycle.
module blit_pixel_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic draw_en,
    input  logic sprite_bit,
    input  logic old_bit,
    output logic new_bit,
    output logic erased
);

    // New pixel value written back to the framebuffer.
    always_comb begin
        new_bit = old_bit ^ sprite_bit;
    end

    // Erase flag: cleared by an accepted start, set on any 1 -> 0 pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erased <= 1'b0;
        end else if (clr) begin
            erased <= 1'b0;
        end else if (draw_en && sprite_bit && old_bit) begin
            erased <= 1'b1;
        end
    end

    // R5: outside drawing and without a new start the flag must not move.
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!draw_en && !clr) |=> $stable(erased));

    // R5: an accepted start leaves the flag cleared.
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !erased);

endmodule

// File: rtl/blit_seq.sv
// Draw sequencer.
// Latches the draw parameters on an accepted start, then for each row issues
// one memory read, captures the returned byte the next cycle and walks its
// eight pixels MSB first, one per cycle. Ends with a one-cycle DONE state.
// Assumes memory data is valid exactly one cycle after the read request.
module blit_seq
    import sprite_blit_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int COORD_W  = 8,
    parameter int HEIGHT_W = 4,
    parameter int BIT_W    = $clog2(PIX_PER_ROW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   spr_base,
    input  logic [COORD_W-1:0]  pos_x,
    input  logic [COORD_W-1:0]  pos_y,
    input  logic [HEIGHT_W-1:0] spr_rows,
    input  logic [7:0]          mem_rdata,
    output logic                accept,
    output logic                busy,
    output logic                done,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                draw_en,
    output logic                sprite_bit,
    output logic [COORD_W-1:0]  org_x,
    output logic [COORD_W-1:0]  org_y,
    output logic [HEIGHT_W-1:0] row_idx,
    output logic [BIT_W-1:0]    bit_idx
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PIX_PER_ROW - 1);

    blit_state_e               state;
    logic [ADDR_W-1:0]         base_q;
    logic [HEIGHT_W-1:0]       rows_q;
    logic [PIX_PER_ROW-1:0]    row_sh;
    logic                      last_row;

    // Start is taken only when no draw is running.
    always_comb begin
        accept = start && (state == ST_IDLE || state == ST_DONE);
    end

    // State-derived strobes towards memory, framebuffer and caller.
    always_comb begin
        busy       = (state == ST_FETCH) || (state == ST_WAIT) || (state == ST_DRAW);
        done       = (state == ST_DONE);
        mem_rd     = (state == ST_FETCH);
        draw_en    = (state == ST_DRAW);
        sprite_bit = row_sh[PIX_PER_ROW-1];
        mem_addr   = base_q + ADDR_W'(row_idx);
        last_row   = ({1'b0, row_idx} + 1'b1) == {1'b0, rows_q};
    end

    // Main sequencing of rows and pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            base_q  <= '0;
            rows_q  <= '0;
            org_x   <= '0;
            org_y   <= '0;
            row_idx <= '0;
            bit_idx <= '0;
            row_sh  <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        base_q  <= spr_base;
                        rows_q  <= spr_rows;
                        org_x   <= pos_x;
                        org_y   <= pos_y;
                        row_idx <= '0;
                        bit_idx <= '0;
                        state   <= (spr_rows == '0) ? ST_DONE : ST_FETCH;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    row_sh  <= mem_rdata;
                    bit_idx <= '0;
                    state   <= ST_DRAW;
                end
                ST_DRAW: begin
                    row_sh <= {row_sh[PIX_PER_ROW-2:0], 1'b0};
                    if (bit_idx == LAST_BIT) begin
                        bit_idx <= '0;
                        if (last_row) begin
                            state <= ST_DONE;
                        end else begin
                            row_idx <= row_idx + 1'b1;
                            state   <= ST_FETCH;
                        end
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: a start during a running draw must not alter the latched parameters.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(base_q) && $stable(rows_q)
                             && $stable(org_x) && $stable(org_y)));

    // R8: completion is a single-cycle pulse unless a new empty draw follows.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R2: the fetch of each further row targets the next consecutive address.
    p_next_row_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(draw_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: rtl/sprite_xor_blitter.sv
// Top of the XOR sprite blitter.
// Joins the sequencer, the pixel address generator and the pixel merge.
// Assumes the framebuffer port returns the bit at fb_addr in the same cycle
// and writes fb_wdata at the next edge when fb_wr is high.
module sprite_xor_blitter
    import sprite_blit_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int COORD_W  = 8,
    parameter int HEIGHT_W = 4,
    parameter int COLS     = 64,
    parameter int ROWS     = 32,
    parameter int FB_AW    = $clog2(COLS * ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   spr_base,
    input  logic [COORD_W-1:0]  pos_x,
    input  logic [COORD_W-1:0]  pos_y,
    input  logic [HEIGHT_W-1:0] spr_rows,
    output logic                busy,
    output logic                done,
    output logic                collide,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [7:0]          mem_rdata,
    output logic [FB_AW-1:0]    fb_addr,
    input  logic                fb_rdata,
    output logic                fb_wr,
    output logic                fb_wdata
);

    localparam int BIT_W = $clog2(PIX_PER_ROW);

    logic                accept;
    logic                draw_en;
    logic                sprite_bit;
    logic [COORD_W-1:0]  org_x;
    logic [COORD_W-1:0]  org_y;
    logic [HEIGHT_W-1:0] row_idx;
    logic [BIT_W-1:0]    bit_idx;

    blit_seq #(
        .ADDR_W   (ADDR_W),
        .COORD_W  (COORD_W),
        .HEIGHT_W (HEIGHT_W),
        .BIT_W    (BIT_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .spr_base   (spr_base),
        .pos_x      (pos_x),
        .pos_y      (pos_y),
        .spr_rows   (spr_rows),
        .mem_rdata  (mem_rdata),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .draw_en    (draw_en),
        .sprite_bit (sprite_bit),
        .org_x      (org_x),
        .org_y      (org_y),
        .row_idx    (row_idx),
        .bit_idx    (bit_idx)
    );

    blit_addr_gen #(
        .COLS     (COLS),
        .ROWS     (ROWS),
        .COORD_W  (COORD_W),
        .HEIGHT_W (HEIGHT_W),
        .BIT_W    (BIT_W),
        .FB_AW    (FB_AW)
    ) addr_i (
        .org_x    (org_x),
        .org_y    (org_y),
        .row_idx  (row_idx),
        .bit_idx  (bit_idx),
        .pix_addr (fb_addr)
    );

    blit_pixel_merge merge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (accept),
        .draw_en    (draw_en),
        .sprite_bit (sprite_bit),
        .old_bit    (fb_rdata),
        .new_bit    (fb_wdata),
        .erased     (collide)
    );

    // Every drawing cycle writes its pixel back.
    always_comb begin
        fb_wr = draw_en;
    end

    // R4: framebuffer writes happen only inside a running draw.
    p_write_in_draw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_wr |-> busy);

    // R7: an accepted empty draw completes on the next cycle.
    p_empty_draw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && spr_rows == '0) |=> (done && !busy));

    // R1/R7: no memory read is ever issued outside a running draw.
    p_read_in_draw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

endmodule

// File: tb/sprite_xor_blitter_tb_top.sv
`timescale 1ns/1ps
module sprite_xor_blitter_tb_top;

    localparam int FB_N = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] spr_base = '0;
    logic [7:0]  pos_x = '0;
    logic [7:0]  pos_y = '0;
    logic [3:0]  spr_rows = '0;
    logic        busy, done, collide, mem_rd, fb_wr, fb_wdata;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [10:0] fb_addr;
    logic        fb_rdata;

    logic fb     [FB_N];
    logic ref_fb [FB_N];

    int n_checks = 0;
    int n_fail   = 0;
    int rd_cnt   = 0;
    int wr_cnt   = 0;
    logic [11:0] rd_log [64];

    always #10 clk = ~clk;

    sprite_xor_blitter dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .spr_base(spr_base),
        .pos_x(pos_x), .pos_y(pos_y), .spr_rows(spr_rows),
        .busy(busy), .done(done), .collide(collide),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .fb_addr(fb_addr), .fb_rdata(fb_rdata), .fb_wr(fb_wr), .fb_wdata(fb_wdata)
    );

    // Sprite memory contents, computed.
    function automatic logic [7:0] rom(input logic [11:0] a);
        if (a >= 12'h100 && a <= 12'h10F) return 8'hFF;
        case (a)
            12'h200: return 8'h80;
            12'h201: return 8'h3C;
            12'hFFF: return 8'hA5;
            12'h000: return 8'h5A;
            default: return 8'h00;
        endcase
    endfunction

    // Memory with one-cycle read latency, plus a read log.
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= rom(mem_addr);
            rd_log[rd_cnt % 64] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    // Framebuffer with same-cycle read and write on the edge.
    assign fb_rdata = fb[fb_addr];
    always @(posedge clk) begin
        if (fb_wr) begin
            fb[fb_addr] <= fb_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference draw from the requirements (R3, R4, R5, R6).
    task automatic ref_draw(input logic [11:0] b, input logic [7:0] x, y,
                            input logic [3:0] n, output logic col);
        col = 1'b0;
        for (int r = 0; r < int'(n); r++) begin
            logic [7:0] byt;
            byt = rom(b + 12'(r));
            for (int k = 0; k < 8; k++) begin
                int a;
                logic sb;
                a  = ((int'(y) + r) % 32) * 64 + ((int'(x) + k) % 64);
                sb = byt[7-k];
                if (sb && ref_fb[a]) col = 1'b1;
                ref_fb[a] = ref_fb[a] ^ sb;
            end
        end
    endtask

    function automatic int fb_mismatch();
        int m = 0;
        for (int i = 0; i < FB_N; i++) if (fb[i] !== ref_fb[i]) m++;
        return m;
    endfunction

    // Issue one draw and measure its latency; optionally poke start mid-draw.
    task automatic run_draw(input logic [11:0] b, input logic [7:0] x, y,
                            input logic [3:0] n, input bit inject,
                            output int cycles);
        @(negedge clk);
        spr_base = b; pos_x = x; pos_y = y; spr_rows = n; start = 1'b1;
        @(posedge clk);
        cycles = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cycles < 400) begin
            if (inject && cycles == 3) begin
                start = 1'b1; spr_base = 12'h100; pos_x = 8'd0;
                pos_y = 8'd0; spr_rows = 4'd5;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
        start = 1'b0;
        if (cycles >= 400) check(1'b0, "R8", "draw hung, cycles", cycles, 10 * int'(n) + 1);
    endtask

    // Stimulus and expected erase flag: {base, x, y, rows, collide}.
    localparam int NV = 9;
    localparam logic [32:0] VEC [NV] = '{
        {12'h100, 8'd0,  8'd0,  4'd2,  1'b0},
        {12'h100, 8'd0,  8'd0,  4'd2,  1'b1},
        {12'h200, 8'd63, 8'd31, 4'd1,  1'b0},
        {12'h100, 8'd60, 8'd31, 4'd2,  1'b1},
        {12'h300, 8'd5,  8'd5,  4'd3,  1'b0},
        {12'h100, 8'd70, 8'd40, 4'd1,  1'b0},
        {12'hFFF, 8'd20, 8'd12, 4'd2,  1'b0},
        {12'h201, 8'd20, 8'd12, 4'd1,  1'b1},
        {12'h100, 8'd0,  8'd0,  4'd15, 1'b1}
    };

    // Watchdog: a hung run ends as a failure.
    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        int rd0, wr0;
        logic rcol;
        for (int i = 0; i < FB_N; i++) begin fb[i] = 1'b0; ref_fb[i] = 1'b0; end

        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !collide && !mem_rd && !fb_wr, "R1",
              "outputs in reset", {busy, done, collide, mem_rd, fb_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !collide && !mem_rd && !fb_wr, "R1",
              "outputs after reset", {busy, done, collide, mem_rd, fb_wr}, 0);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            logic [11:0] b;
            logic [7:0]  x, y;
            logic [3:0]  n;
            logic        ec;
            {b, x, y, n, ec} = VEC[v];
            rd0 = rd_cnt; wr0 = wr_cnt;
            run_draw(b, x, y, n, 1'b0, cyc);
            ref_draw(b, x, y, n, rcol);
            check(cyc == 10 * int'(n) + 1, "R8", "latency", cyc, 10 * int'(n) + 1);
            check(collide == ec && rcol == ec, "R5", "collide", int'(collide), int'(ec));
            check(fb_mismatch() == 0, "R6", "framebuffer mismatching pixels (R4 XOR)",
                  fb_mismatch(), 0);
            check(wr_cnt - wr0 == 8 * int'(n), "R4", "write count", wr_cnt - wr0, 8 * int'(n));
            check(rd_cnt - rd0 == int'(n), "R2", "read count", rd_cnt - rd0, int'(n));
            for (int r = 0; r < int'(n); r++)
                check(rd_log[(rd0 + r) % 64] == b + 12'(r), "R2", "read address",
                      int'(rd_log[(rd0 + r) % 64]), int'(b + 12'(r)));
            @(negedge clk);
            check(!done && collide == ec, "R8", "done pulse width / R5 hold",
                  {done, collide}, {1'b0, ec});
            if (v == 2) begin
                // R3: byte 0x80 lights only the leftmost pixel (63,31).
                check(fb[31*64 + 63] == 1'b1, "R3", "bit7 pixel", int'(fb[31*64+63]), 1);
                check(fb[31*64 + 6] == 1'b0, "R3", "bit0 pixel (wrapped)", int'(fb[31*64+6]), 0);
            end
            if (v == 6)
                check(rd_log[(rd0 + 1) % 64] == 12'h000, "R2", "address wrap",
                      int'(rd_log[(rd0 + 1) % 64]), 0);
        end

        // R7: empty draw right after a draw that set collide.
        rd0 = rd_cnt; wr0 = wr_cnt;
        run_draw(12'h100, 8'd3, 8'd3, 4'd0, 1'b0, cyc);
        check(cyc == 1, "R7", "empty draw latency", cyc, 1);
        check(collide == 1'b0, "R7", "empty draw collide", int'(collide), 0);
        check(rd_cnt == rd0 && wr_cnt == wr0, "R7", "empty draw accesses",
              (rd_cnt - rd0) + (wr_cnt - wr0), 0);
        check(fb_mismatch() == 0, "R7", "framebuffer untouched", fb_mismatch(), 0);

        // R9: start while busy is ignored.
        rd0 = rd_cnt; wr0 = wr_cnt;
        run_draw(12'h201, 8'd40, 8'd20, 4'd2, 1'b1, cyc);
        ref_draw(12'h201, 8'd40, 8'd20, 4'd2, rcol);
        check(cyc == 21, "R9", "latency with ignored start", cyc, 21);
        check(fb_mismatch() == 0, "R9", "framebuffer mismatching pixels", fb_mismatch(), 0);
        check(wr_cnt - wr0 == 16, "R9", "write count", wr_cnt - wr0, 16);
        check(collide == rcol, "R9", "collide", int'(collide), int'(rcol));
        @(negedge clk);
        check(!busy && !done, "R9", "engine idle afterwards", {busy, done}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule